// File: doc/BRIEF.md
# 8-bit ALU with Flag Register

An 8-bit arithmetic and logic unit of the kind found in classic accumulator-based microprocessors. Each cycle it takes an operation code and two byte operands. It returns the byte result at once, as combinational logic. The eight condition flags sit in a register inside the block. The current register value supplies the incoming carry and every flag that an operation leaves alone. The next flag byte is loaded into the register only on cycles that the caller marks as valid.

The operations are: add and subtract, each with or without the stored carry; compare; the three bitwise operations; increment and decrement; the four accumulator rotates; complement; set carry; and invert carry. All of them follow the exact per-flag rules that software for such processors relies on. This includes the two result-bit copies that sit between the documented flags, and the flags that some operations must preserve. Instruction decode, memory access and 16-bit arithmetic belong to the surrounding core.

Top module: `byte_alu`

## Requirements
- R1: The flag byte is, from bit 0 to bit 7: C carry, N subtract, PV parity/overflow, X copy, H half-carry, Y copy, Z zero, S sign; it resets to 0x00.
- R2: flags_o takes the next flag byte on a rising clock edge only when op_valid_i is 1; otherwise it holds.
- R3: Codes 0 (add) and 1 (add with carry-in C) give the low 8 bits of a_i+b_i(+C); C is bit 8 of the sum, H is the carry out of bit 3, PV is set when both operands share a sign that the result lacks, N is 0.
- R4: Codes 2 (subtract) and 3 (subtract with borrow C) give a_i-b_i(-C); C is the borrow, H is the borrow from bit 4, PV is set when the operand signs differ and the result sign differs from a_i, N is 1.
- R5: Code 4 (compare) sets the flags exactly as code 2 does, while result_o stays equal to a_i.
- R6: Codes 5 (AND), 6 (OR) and 7 (XOR) clear C and N, set PV when the result has an even number of ones, and set H to 1 for AND and 0 for the others.
- R7: Code 8 increments and code 9 decrements a_i; PV is set when the result is 0x80 (increment) or 0x7F (decrement); H is set when the low nibble of the result is 0x0 (increment) or 0xF (decrement); N is 0 for increment and 1 for decrement; C is unchanged.
- R8: The rotates are code 10 (left circular), 11 (left through C), 12 (right circular) and 13 (right through C). C takes the bit shifted out. The circular forms feed that bit back in; the others feed in the old C. N and H are cleared, and S, Z and PV are unchanged.
- R9: Code 14 returns the bitwise inverse of a_i and sets N and H; C, S, Z and PV are unchanged.
- R10: Code 15 sets C and clears N and H. Code 16 inverts C, clears N and sets H to the old C. Both return a_i and leave S, Z, PV, X and Y unchanged.
- R11: For codes 0 to 14, X and Y copy bits 3 and 5 of the computed result (for code 4, of the difference). For codes 0 to 9, S copies result bit 7 and Z is set when the result is zero.
- R12: Codes 17 to 31 return a_i and leave the flags unchanged even when op_valid_i is 1.
- R13: result_o reflects the inputs and the current flag register in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Commits the next flag byte at the coming edge |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (accumulator) |
| b_i | input | 8 | Second operand |
| result_o | output | 8 | Combinational result |
| flags_o | output | 8 | Registered flag byte |

## Verification
The coupling that matters is between the combinational result path and the flag register update. A carry-consuming operation reads the C bit that the operation just before it wrote at the clock edge between them. The bench therefore interleaves all seventeen operations back to back over a sweep of operand pairs, so that add-with-carry, subtract-with-borrow and the through-carry rotates always depend on the flag update of the previous cycle. The result is compared in the middle of the cycle, and the flag byte after the edge, against a behavioural model that carries its own flag state. Cycles with op_valid_i low are mixed in to show that the result still appears while the register holds.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int FLAG_W = 8;
  localparam int OP_W   = 5;
  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_X  = 3;
  localparam int FL_H  = 4;
  localparam int FL_Y  = 5;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RL  = 5'd11,
    OP_RRC = 5'd12, OP_RR  = 5'd13, OP_CPL = 5'd14, OP_SCF = 5'd15,
    OP_CCF = 5'd16
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 5'd16;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = DATA_W - 1;

  logic              is_sub, is_step, cin;
  logic [DATA_W-1:0] opb, hx;
  logic [DATA_W:0]   sum;
  logic              ovf;

  always_comb begin
    is_sub  = op_i inside {OP_SUB, OP_SBC, OP_CMP, OP_DEC};
    is_step = op_i inside {OP_INC, OP_DEC};
    opb     = is_step ? DATA_W'(1) : b_i;
    cin     = (op_i inside {OP_ADC, OP_SBC}) ? flags_i[FL_C] : 1'b0;
    if (is_sub) sum = {1'b0, a_i} - {1'b0, opb} - {{DATA_W{1'b0}}, cin};
    else        sum = {1'b0, a_i} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
    res_o = sum[MSB:0];
    hx    = a_i ^ opb ^ res_o;
    // sign rule: same-sign operands for add, differing for subtract
    ovf   = is_sub ? ((a_i[MSB] ^ opb[MSB]) & (a_i[MSB] ^ res_o[MSB]))
                   : (~(a_i[MSB] ^ opb[MSB]) & (a_i[MSB] ^ res_o[MSB]));
    flags_o        = '0;
    flags_o[FL_C]  = is_step ? flags_i[FL_C] : sum[DATA_W];
    flags_o[FL_N]  = is_sub;
    flags_o[FL_PV] = ovf;
    flags_o[FL_X]  = res_o[3];
    flags_o[FL_H]  = hx[4];
    flags_o[FL_Y]  = res_o[5];
    flags_o[FL_Z]  = (res_o == '0);
    flags_o[FL_S]  = res_o[MSB];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    flags_o = flags_i;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
    if (op_i == OP_CPL) begin
      flags_o[FL_N] = 1'b1;
      flags_o[FL_H] = 1'b1;
    end else begin
      flags_o[FL_C]  = 1'b0;
      flags_o[FL_N]  = 1'b0;
      flags_o[FL_PV] = ~^res_o;
      flags_o[FL_H]  = (op_i == OP_AND);
      flags_o[FL_Z]  = (res_o == '0);
      flags_o[FL_S]  = res_o[MSB];
    end
    flags_o[FL_X] = res_o[3];
    flags_o[FL_Y] = res_o[5];
  end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int MSB = DATA_W - 1;

  logic c_old;

  always_comb begin
    c_old   = flags_i[FL_C];
    flags_o = flags_i;
    res_o   = a_i;
    flags_o[FL_N] = 1'b0;
    flags_o[FL_H] = 1'b0;
    unique case (op_i)
      OP_RLC: begin res_o = {a_i[MSB-1:0], a_i[MSB]}; flags_o[FL_C] = a_i[MSB]; end
      OP_RL:  begin res_o = {a_i[MSB-1:0], c_old};    flags_o[FL_C] = a_i[MSB]; end
      OP_RRC: begin res_o = {a_i[0], a_i[MSB:1]};     flags_o[FL_C] = a_i[0];   end
      OP_RR:  begin res_o = {c_old, a_i[MSB:1]};      flags_o[FL_C] = a_i[0];   end
      OP_SCF: flags_o[FL_C] = 1'b1;
      default: begin
        flags_o[FL_C] = ~c_old;
        flags_o[FL_H] = c_old;
      end
    endcase
    // only rotates publish result bits; carry ops keep X/Y
    if (op_i inside {OP_RLC, OP_RL, OP_RRC, OP_RR}) begin
      flags_o[FL_X] = res_o[3];
      flags_o[FL_Y] = res_o[5];
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  alu_op_e           op;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [DATA_W-1:0] res;
  logic [DATA_W-1:0] as_res, lg_res, rt_res;
  logic [FLAG_W-1:0] as_fl, lg_fl, rt_fl;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op_i(op), .a_i(a_i), .b_i(b_i), .flags_i(flags_q),
    .res_o(as_res), .flags_o(as_fl)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .flags_i(flags_q),
    .res_o(lg_res), .flags_o(lg_fl)
  );

  alu_rotate #(.DATA_W(DATA_W)) u_rotate (
    .op_i(op), .a_i(a_i), .flags_i(flags_q),
    .res_o(rt_res), .flags_o(rt_fl)
  );

  always_comb begin
    res     = a_i;
    flags_d = flags_q;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
        res = as_res; flags_d = as_fl;
      end
      OP_CMP: flags_d = as_fl;  // difference discarded
      OP_AND, OP_OR, OP_XOR, OP_CPL: begin
        res = lg_res; flags_d = lg_fl;
      end
      OP_RLC, OP_RL, OP_RRC, OP_RR, OP_SCF, OP_CCF: begin
        res = rt_res; flags_d = rt_fl;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags_q <= '0;
    else if (op_valid_i) flags_q <= flags_d;
  end

  assign result_o = res;
  assign flags_o  = flags_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> flags_q == $past(flags_q));

  assert_cmp_keeps_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CMP |-> result_o == a_i);

  assert_logic_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i inside {OP_AND, OP_OR, OP_XOR})
      |=> !flags_q[FL_C] && !flags_q[FL_N] && flags_q[FL_H] == $past(op_i == OP_AND));

  assert_step_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i inside {OP_INC, OP_DEC})
      |=> flags_q[FL_C] == $past(flags_q[FL_C]));

  assert_rot_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i inside {OP_RLC, OP_RL, OP_RRC, OP_RR})
      |=> flags_q[FL_S] == $past(flags_q[FL_S]) && flags_q[FL_Z] == $past(flags_q[FL_Z])
          && flags_q[FL_PV] == $past(flags_q[FL_PV]) && !flags_q[FL_N] && !flags_q[FL_H]);

  assert_scf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_SCF) |=> flags_q[FL_C] && !flags_q[FL_N] && !flags_q[FL_H]);

  assert_ccf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_CCF)
      |=> flags_q[FL_C] != $past(flags_q[FL_C]) && flags_q[FL_H] == $past(flags_q[FL_C]));

  assert_undef_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_LAST) |-> result_o == a_i ##1 $stable(flags_q));
endmodule

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [7:0] result_o, flags_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model_f = 8'h00;

  always #10 clk_i = ~clk_i;

  byte_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o)
  );

  function automatic string tag_of(int op);
    if (op <= 1)  return "R3";
    if (op <= 3)  return "R4";
    if (op == 4)  return "R5";
    if (op <= 7)  return "R6";
    if (op <= 9)  return "R7";
    if (op <= 13) return "R8";
    if (op == 14) return "R9";
    if (op <= 16) return "R10";
    return "R12";
  endfunction

  // behavioural reference: {result, next flags}
  function automatic logic [15:0] ref_model(int op, int a, int b, logic [7:0] f);
    int r, s, cc, c, ones, outv;
    logic [7:0] nf;
    nf = f; c = f[0]; r = a; cc = 0;
    case (op)
      0, 1: begin
        cc = (op == 1) ? c : 0;
        s = a + b + cc; r = s & 255;
        nf[0] = s > 255; nf[1] = 0;
        nf[2] = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128));
        nf[4] = ((a & 15) + (b & 15) + cc) > 15;
      end
      2, 3, 4: begin
        cc = (op == 3) ? c : 0;
        s = a - b - cc; r = s & 255;
        nf[0] = s < 0; nf[1] = 1;
        nf[2] = ((a >= 128) != (b >= 128)) && ((r >= 128) != (a >= 128));
        nf[4] = ((a & 15) - (b & 15) - cc) < 0;
      end
      5, 6, 7: begin
        r = (op == 5) ? (a & b) : (op == 6) ? (a | b) : (a ^ b);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        nf[0] = 0; nf[1] = 0; nf[2] = (ones % 2) == 0; nf[4] = (op == 5);
      end
      8: begin
        r = (a + 1) & 255; nf[1] = 0; nf[2] = (r == 128); nf[4] = (r & 15) == 0;
      end
      9: begin
        r = (a + 255) & 255; nf[1] = 1; nf[2] = (r == 127); nf[4] = (r & 15) == 15;
      end
      10: begin r = ((a << 1) | (a >> 7)) & 255; nf[0] = a >= 128; end
      11: begin r = ((a << 1) | c) & 255;        nf[0] = a >= 128; end
      12: begin r = (a >> 1) | ((a & 1) << 7);   nf[0] = a & 1;    end
      13: begin r = (a >> 1) | (c << 7);         nf[0] = a & 1;    end
      14: begin r = (~a) & 255; nf[1] = 1; nf[4] = 1; end
      15: begin nf[0] = 1; nf[1] = 0; nf[4] = 0; end
      16: begin nf[0] = !c; nf[1] = 0; nf[4] = c; end
      default: ;
    endcase
    if (op >= 10 && op <= 13) begin nf[1] = 0; nf[4] = 0; end
    if (op <= 14) begin nf[3] = (r >> 3) & 1; nf[5] = (r >> 5) & 1; end
    if (op <= 9)  begin nf[6] = (r == 0); nf[7] = r >= 128; end
    outv = (op == 4 || op >= 15) ? a : r;
    return {8'(outv), nf};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  // drive at negedge, check result mid-cycle, check flags after the edge
  task automatic do_op(int op, int a, int b, bit valid);
    logic [15:0] e;
    @(negedge clk_i);
    op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); op_valid_i = valid;
    #2;
    e = ref_model(op, a, b, model_f);
    check(result_o == e[15:8], tag_of(op), "result R13", result_o, e[15:8]);
    @(posedge clk_i); #2;
    if (valid && op <= 16) model_f = e[7:0];
    check(flags_o == model_f, valid ? tag_of(op) : "R2", "flags", flags_o, model_f);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk_i);
    #2 check(flags_o == 8'h00, "R1", "reset flags", flags_o, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    // R3: FF+01 -> 00 with Z,H,C set (0x51 in the R1 layout)
    do_op(0, 8'hFF, 8'h01, 1);
    check(flags_o == 8'h51, "R3", "FF+01 flags", flags_o, 8'h51);
    // R13: carry just written feeds ADC in the next cycle
    do_op(15, 0, 0, 1);
    do_op(1, 0, 0, 1);
    // R7: 7F+1 sets PV and H, keeps C=0
    do_op(8, 8'h7F, 0, 1);
    check(flags_o == 8'h94, "R7", "inc 7F flags", flags_o, 8'h94);
    // R2: invalid cycle, result still shown, flags held
    do_op(2, 8'h00, 8'h01, 0);
    check(flags_o == 8'h94, "R2", "held flags", flags_o, 8'h94);
    // R12: undefined codes ignored even when valid
    for (int op = 17; op < 32; op++) do_op(op, 8'hA5, 8'h3C, 1);
    check(flags_o == 8'h94, "R12", "undefined op flags", flags_o, 8'h94);

    // R11 and all op checks: interleaved sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17)
        for (int op = 0; op <= 16; op++)
          do_op(op, a, b ^ (a & 8'h11), ((a + b + op) % 23) != 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule